// File: doc/BRIEF.md
# FIFO Controller with Read-Pointer Rewind

A single-clock first-in first-out buffer controller for 9-bit words. A producer writes by pulling an active-low write strobe low; a consumer reads by pulling an active-low read strobe low. The block samples both strobes on the clock and acts on their falling edges. Read and write locations come from internal pointers, so no address ever crosses the boundary. Two active-low flags tell the producer when the store is full and the consumer when it is empty. A strobe that arrives while its flag blocks it is dropped without side effects.

A read stays in progress for as long as the read strobe is held low. During that time the word is presented on `rdata`, qualified by `rdata_vld`, and the word is consumed when the strobe returns high. If the read strobe falls while the store is empty, the controller waits. The first word written afterwards is passed straight to the output, without a later read edge being needed.

An active-low rewind input returns the read pointer to location zero and leaves the write pointer alone. Everything written since reset can then be replayed, provided no more than `DEPTH` words were written. `DEPTH` must be a power of two.

Top module: `retx_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties itself: after that edge `empty_n` is 0, `full_n` is 1 and `rdata_vld` is 0.
- R2: A write is a 1-to-0 change of `wr_n` between two consecutive clock samples while `full_n` is 1. The block stores `wdata` at that edge, and `empty_n` is 1 after it.
- R3: A falling `wr_n` seen while `full_n` is 0 is dropped. No stored word changes and no pointer moves, so the words drained afterwards are exactly the ones held before.
- R4: A falling `rd_n` seen while `empty_n` is 1 starts a read. At that edge `rdata` takes the oldest unread word and `rdata_vld` rises. Both hold while `rd_n` stays 0. The clock edge that first samples `rd_n` at 1 consumes the word and clears `rdata_vld`.
- R5: A falling `rd_n` seen while `empty_n` is 0, released again before any write, has no effect: `rdata_vld` stays 0 and no word is consumed.
- R6: With no reads since reset, `full_n` goes to 0 at the edge that accepts the `DEPTH`-th write. It returns to 1 at the edge that completes a read.
- R7: `empty_n` returns to 0 at the edge that completes the read of the last stored word.
- R8: A clock sample of `rt_n` at 0 sets the read pointer to location zero and keeps the write pointer. It also ends any read in progress, and strobe edges seen in the same cycle are dropped. The reads that follow replay every word written since reset, in order.
- R9: If `rd_n` fell on an empty store and is still 0, the edge that accepts the next write also drives that word onto `rdata` with `rdata_vld` high. Further writes while `rd_n` stays 0 do not change `rdata`. Releasing `rd_n` consumes the word.
- R10: A write accepted at the same edge that completes a read applies both operations. Occupancy is unchanged and no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, acts on its falling edge |
| rd_n | input | 1 | Read strobe, active low, read lasts while held low |
| rt_n | input | 1 | Rewind request, active low, read pointer to zero |
| wdata | input | WIDTH | Word to be written |
| rdata | output | WIDTH | Word under read, meaningful while `rdata_vld` is 1 |
| rdata_vld | output | 1 | High while an accepted read is in progress |
| empty_n | output | 1 | Low when no unread word is stored |
| full_n | output | 1 | Low when DEPTH unread words are stored |

## Verification
Two pairs of functions can fall on the same edge. The first pair is the completion of a read and the acceptance of a write. The directed case provokes it by releasing `rd_n` and dropping `wr_n` at the same instant, then drains the store and checks that every word arrives exactly once and in order. The second pair is a read that started on an empty store and a newly accepted write, which together form the flow-through path. The bench holds `rd_n` low on an empty store and checks that the written word and its valid bit appear one edge after the write strobe falls. A long pseudo-random phase mixes both collisions with fills and drains. In every cycle it compares flags, valid bit and data against a queue model.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  // index of each strobe inside the sampled strobe vector
  localparam int STB_WR = 0;
  localparam int STB_RD = 1;
  localparam int STB_N  = 2;

  // address bits for a given depth (never below one)
  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int N        = 2,
  parameter int RISE_IDX = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic         rise_sel
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fall[i] = prev_q[i] & ~lvl_n[i];
  end

  assign rise_sel = ~prev_q[RISE_IDX] & lvl_n[RISE_IDX];
endmodule

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = addr_bits(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rewind,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output logic          full_n
);
  logic [PW-1:0] wptr, rptr, wptr_nx, rptr_nx, occ_nx;

  always_comb begin
    wptr_nx = wptr + PW'(wr_en);
    rptr_nx = rewind ? '0 : rptr + PW'(rd_en);
    occ_nx  = wptr_nx - rptr_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
    end else begin
      wptr    <= wptr_nx;
      rptr    <= rptr_nx;
      empty_n <= (occ_nx != '0);
      full_n  <= (occ_nx != PW'(DEPTH));
    end
  end

  assign waddr = wptr[AW-1:0];
  assign raddr = rptr[AW-1:0];

  // R3: the top must never present a write while full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !wr_en) else $error("write presented while full");

  // R7: the top must never complete a read while empty
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !rd_en) else $error("read completed while empty");

  // R8: rewind clears the read pointer and keeps the write pointer
  a_r8_rewind_keeps_wptr: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rptr == '0 && wptr == $past(wptr))) else $error("rewind moved write pointer");
endmodule

// File: rtl/word_ram.sv
module word_ram
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW   = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rq
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             rdata_vld,
  output logic             empty_n,
  output logic             full_n
);
  localparam int AW = addr_bits(DEPTH);

  logic [STB_N-1:0] stb_n, stb_fall;
  logic             rd_rise;
  logic             wr_acc, rd_try, rd_mem, rd_ft, rd_park, rd_done;
  logic             rd_act, rd_wait, use_ft;
  logic [WIDTH-1:0] ft_q, ram_q;
  logic [AW-1:0]    waddr, raddr;

  always_comb begin
    stb_n         = '1;
    stb_n[STB_WR] = wr_n;
    stb_n[STB_RD] = rd_n;
  end

  strobe_edge #(.N(STB_N), .RISE_IDX(STB_RD)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl_n    (stb_n),
    .fall     (stb_fall),
    .rise_sel (rd_rise)
  );

  // request decode: rewind blocks every strobe in its cycle
  always_comb begin
    wr_acc  = stb_fall[STB_WR] & full_n & rt_n;
    rd_try  = rt_n & ~rd_act & ~rd_n & (stb_fall[STB_RD] | rd_wait);
    rd_mem  = rd_try & empty_n;
    rd_ft   = rd_try & ~empty_n & wr_acc;
    rd_park = rd_try & ~empty_n & ~wr_acc;
    rd_done = rt_n & rd_act & rd_rise;
  end

  fifo_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_acc),
    .rd_en   (rd_done),
    .rewind  (~rt_n),
    .waddr   (waddr),
    .raddr   (raddr),
    .empty_n (empty_n),
    .full_n  (full_n)
  );

  word_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk (clk),
    .we  (wr_acc),
    .wa  (waddr),
    .wd  (wdata),
    .re  (rd_mem),
    .ra  (raddr),
    .rq  (ram_q)
  );

  // read sequencing: active read, parked read on empty, bypass select
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      rd_wait <= 1'b0;
      use_ft  <= 1'b0;
    end else if (!rt_n) begin
      rd_act  <= 1'b0;
      rd_wait <= 1'b0;
    end else begin
      if (rd_mem || rd_ft) rd_act <= 1'b1;
      else if (rd_done)    rd_act <= 1'b0;
      if (rd_park)                     rd_wait <= 1'b1;
      else if (rd_mem || rd_ft || rd_rise) rd_wait <= 1'b0;
      if (rd_ft)       use_ft <= 1'b1;
      else if (rd_mem) use_ft <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_ft) ft_q <= wdata;
  end

  assign rdata     = use_ft ? ft_q : ram_q;
  assign rdata_vld = rd_act;

  // R1: reset leaves the block empty and idle
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!empty_n && full_n && !rdata_vld)) else $error("reset state wrong");

  // R4: an active read holds word and valid while the strobe stays low
  a_r4_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rdata_vld && !rd_n && rt_n) |=> (rdata_vld && $stable(rdata))) else $error("read dropped early");

  // R9: flow-through presents the word being written
  a_r9_flow_through: assert property (@(posedge clk) disable iff (rst)
    rd_ft |=> (rdata_vld && rdata == $past(wdata))) else $error("flow-through word wrong");
endmodule

// File: tb/sim_retx_fifo.sv
`timescale 1ns/1ps
module sim_retx_fifo;
  localparam int W = 9;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic rdata_vld, empty_n, full_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  retx_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld),
    .empty_n(empty_n), .full_n(full_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- queue reference model ----------------
  logic [W-1:0] hist[$];
  int  ridx = 0;
  bit  busy = 0, waiting = 0, mvld = 0, started = 0;
  bit  pw = 1, pr = 1, wf, rf, rr, wacc, tr;
  int  occ;
  logic [W-1:0] mout = '0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      hist.delete(); ridx = 0; busy = 0; waiting = 0; mvld = 0; pw = 1; pr = 1;
    end else begin
      wf = pw && !wr_n; rf = pr && !rd_n; rr = !pr && rd_n;
      occ = hist.size() - ridx;
      if (!rt_n) begin
        ridx = 0; busy = 0; waiting = 0; mvld = 0;
      end else begin
        wacc = wf && (occ < D);
        tr = !busy && !rd_n && (rf || waiting);
        if (tr && occ > 0) begin
          mout = hist[ridx]; mvld = 1; busy = 1; waiting = 0;
        end else if (tr && wacc) begin
          mout = wdata; mvld = 1; busy = 1; waiting = 0;
        end else if (tr) waiting = 1;
        if (rr) waiting = 0;
        if (rr && busy) begin ridx++; busy = 0; mvld = 0; end
        if (wacc) hist.push_back(wdata);
      end
      pw = wr_n; pr = rd_n;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R7 empty_n vs model", empty_n, (hist.size() - ridx) != 0);
      check("R6 full_n vs model", full_n, (hist.size() - ridx) != D);
      check("R4 rdata_vld vs model", rdata_vld, mvld);
      if (mvld) check("R4 rdata vs model", rdata, mout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    @(negedge clk); rst = 1; wr_n = 1; rd_n = 1; rt_n = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [W-1:0] d);
    @(negedge clk); wr_n = 0; wdata = d;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic do_rd(output logic [W-1:0] d, output bit v);
    @(negedge clk); rd_n = 0;
    @(negedge clk); d = rdata; v = rdata_vld; rd_n = 1;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed and random phases ----------------
  logic [W-1:0] d;
  bit v;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // R1 reset state
    do_reset();
    check("R1 empty_n after reset", empty_n, 0);
    check("R1 full_n after reset", full_n, 1);
    check("R1 rdata_vld after reset", rdata_vld, 0);

    // R5 read on empty, released before any write
    do_rd(d, v);
    check("R5 no valid on empty read", v, 0);
    check("R5 still empty", empty_n, 0);

    // R2 writes
    do_wr(9'h0A0);
    check("R2 empty_n high after first write", empty_n, 1);
    for (int i = 1; i < 5; i++) do_wr(9'(9'h0A0 + i));

    // R4 reads in order
    for (int i = 0; i < 2; i++) begin
      do_rd(d, v);
      check("R4 read valid", v, 1);
      check("R4 read data", d, 9'h0A0 + i);
    end

    // R10 read completion and write acceptance on the same edge
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    check("R10 word before collision", rdata, 9'h0A2);
    rd_n = 1; wr_n = 0; wdata = 9'h0A5;
    @(negedge clk); wr_n = 1;
    for (int i = 3; i < 6; i++) begin
      do_rd(d, v);
      check("R10 drained word", d, 9'h0A0 + i);
    end
    check("R10 empty after drain", empty_n, 0);
    do_rd(d, v);
    check("R10 no extra word", v, 0);

    // R6 fill to full, R3 write while full
    do_reset();
    for (int i = 0; i < D; i++) begin
      if (i == D - 1) check("R6 full_n high before last write", full_n, 1);
      do_wr(9'(i));
    end
    check("R6 full_n low after DEPTH writes", full_n, 0);
    do_wr(9'h1FF);
    check("R3 full_n stays low", full_n, 0);
    do_rd(d, v);
    check("R6 first word", d, 0);
    check("R6 full_n high after read", full_n, 1);
    for (int i = 1; i < D; i++) begin
      do_rd(d, v);
      check("R3 drained word unchanged", d, i);
    end
    check("R7 empty after last read", empty_n, 0);
    do_rd(d, v);
    check("R3 blocked word absent", v, 0);

    // R8 rewind replays from location zero
    do_reset();
    for (int i = 0; i < 10; i++) do_wr(9'(9'h100 + i));
    for (int i = 0; i < 4; i++) begin
      do_rd(d, v);
      check("R8 read before rewind", d, 9'h100 + i);
    end
    @(negedge clk); rt_n = 0; wr_n = 0; wdata = 9'h1AA;
    @(negedge clk); rt_n = 1; wr_n = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      do_rd(d, v);
      check("R8 replay valid", v, 1);
      check("R8 replay word", d, 9'h100 + i);
    end
    check("R8 empty after replay", empty_n, 0);
    do_rd(d, v);
    check("R8 write during rewind dropped", v, 0);

    // R9 read flow-through
    do_reset();
    @(negedge clk); rd_n = 0;
    repeat (2) @(negedge clk);
    check("R9 no valid while parked", rdata_vld, 0);
    wr_n = 0; wdata = 9'h155;
    @(negedge clk); wr_n = 1;
    check("R9 flow-through valid", rdata_vld, 1);
    check("R9 flow-through word", rdata, 9'h155);
    @(negedge clk); wr_n = 0; wdata = 9'h0CC;
    @(negedge clk); wr_n = 1;
    check("R9 output held on later write", rdata, 9'h155);
    rd_n = 1;
    @(negedge clk);
    check("R9 consumed on release", rdata_vld, 0);
    check("R9 second word remains", empty_n, 1);
    do_rd(d, v);
    check("R9 later word on next read", d, 9'h0CC);
    check("R9 empty at end", empty_n, 0);

    // pseudo-random mix, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst = (c % 600 == 0);
      if ((c / 300) % 2 == 0) begin
        wr_n = lfsr[0] & lfsr[1];
        rd_n = lfsr[2] | lfsr[3];
      end else begin
        wr_n = lfsr[0] | lfsr[1];
        rd_n = lfsr[2] & lfsr[3];
      end
      wdata = lfsr[12:4];
    end
    @(negedge clk); rst = 0; wr_n = 1; rd_n = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule